// File: doc/BRIEF.md
# Synchronous Fault Escalation Controller

This block decides how a synchronous fault reported by a processor core gets serviced. A fault can come from one of three configurable classes: memory management, bus, or usage. Each raised class brings a cause code. The block compares each class's programmed priority with the priority of the code that is currently executing. It also checks whether a fault handler is already running and which class it serves, and whether the handler for the raised class is enabled.

From these inputs it selects one exception to take. That is either the configured handler of the winning class or the fixed-priority hard fault. When the hard fault is chosen in place of the configured handler, the block raises an escalation flag. One case is exempt from escalation: a bus fault caused by the stack push on entry to the bus fault handler.

Every detected cause sets a sticky status bit, which software clears by writing one. A separate forced bit records that an escalation happened. Two context flags change the recorded cause. A fault taken while stacking on exception entry is recorded as a stacking error. A fault taken while unstacking on exception return is recorded as an unstacking error.

Top module: `fault_route_ctrl`

## Requirements
- R1: While an exception is active (`exec_act_i`=1), a fault whose class priority group is the same as or numerically larger than the executing priority group is escalated: `take_exc_o`=3 (hard fault) and `escalated_o`=1. The priority group is the upper `PRIO_BITS` bits (default 4) of the 8-bit value, and a numerically lower group is more urgent. The lower bits are ignored.
- R2: While a fault handler of class C is active (`fh_act_i`=1, `fh_cls_i`=C), a new fault of class C is escalated to hard fault, even if its priority alone would allow preemption. Class codes are 0 memory management, 1 bus, 2 usage.
- R3: A fault whose class handler is disabled is escalated to hard fault. `hnd_en_i` bit 0 is memory management, bit 1 is bus, bit 2 is usage.
- R4: A bus fault raised during the stack push on entry to the bus handler (`stk_push_i`=1, `stk_tgt_i`=1) is taken as bus fault with `escalated_o`=0. This applies even if R1 or R2 would otherwise escalate it, provided the bus handler is enabled.
- R5: A fault that meets no escalation rule is taken as its own class (`take_exc_o` = class code). In thread mode (`exec_act_i`=0) priority never causes escalation.
- R6: When several classes are raised in one cycle, the class with the lowest priority group is serviced. A tie goes to the lower class code.
- R7: Every raised class sets a sticky status bit for its cause, and the bit holds until cleared. Memory codes are 0 instruction access, 1 data access, 2 stacking, 3 unstacking, 4 lazy FP. Bus codes are 0 stacking, 1 unstacking, 2 prefetch, 3 lazy FP, 4 precise, 5 imprecise. Usage codes are 0 coprocessor, 1 undefined instruction, 2 invalid state, 3 invalid return, 4 unaligned, 5 divide by zero. `stk_push_i` forces the memory and bus codes to their stacking code, and `stk_pop_i` forces them to their unstacking code. Out-of-range codes set no bit.
- R8: A status bit is cleared by a one in the matching clear input. A set in the same cycle wins over the clear.
- R9: Every escalation sets the sticky forced bit `forced_sts_o` together with `escalated_o`. `forced_clr_i` clears the forced bit.
- R10: After reset, every output is zero.
- R11: Results are registered. `take_vld_o` is 1 exactly in the cycle after a cycle with any fault request, and 0 after a cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_req_i | input | 3 | Fault raised per class (bit 0 mem, 1 bus, 2 usage) |
| mm_code_i | input | 3 | Memory-management cause code |
| bus_code_i | input | 3 | Bus cause code |
| use_code_i | input | 3 | Usage cause code |
| stk_push_i | input | 1 | Fault arose during exception-entry stacking |
| stk_pop_i | input | 1 | Fault arose during exception-return unstacking |
| stk_tgt_i | input | 2 | Class of the handler being entered while stacking |
| hnd_en_i | input | 3 | Handler enables per class |
| mm_prio_i | input | 8 | Memory-management priority |
| bus_prio_i | input | 8 | Bus priority |
| use_prio_i | input | 8 | Usage priority |
| exec_act_i | input | 1 | An exception is currently executing |
| exec_prio_i | input | 8 | Current execution priority |
| fh_act_i | input | 1 | A configurable fault handler is executing |
| fh_cls_i | input | 2 | Class of that executing fault handler |
| mm_clr_i | input | 5 | Write-one-to-clear for memory status |
| bus_clr_i | input | 6 | Write-one-to-clear for bus status |
| use_clr_i | input | 6 | Write-one-to-clear for usage status |
| forced_clr_i | input | 1 | Clear for the forced bit |
| take_vld_o | output | 1 | An exception decision is presented |
| take_exc_o | output | 2 | Exception to take: 0 mem, 1 bus, 2 usage, 3 hard fault |
| escalated_o | output | 1 | Decision is an escalation to hard fault |
| mm_sts_o | output | 5 | Sticky memory-management cause bits |
| bus_sts_o | output | 6 | Sticky bus cause bits |
| use_sts_o | output | 6 | Sticky usage cause bits |
| forced_sts_o | output | 1 | Sticky forced-escalation bit |

## Verification
Every result of this block comes from one register stage. The decision, the escalation flag, the status bits and the forced bit all change on the first rising edge after the request is presented. The bench drives each stimulus on a falling edge, lets one rising edge pass, and reads every output on the following falling edge. It then spends one more cycle with no request and every clear asserted. On the falling edge after that cycle it checks that the decision is withdrawn and that all status bits are zero.

// File: rtl/fr_pkg.sv
`timescale 1ns/1ps
package fr_pkg;
  localparam int NCLS   = 3;
  localparam int CODE_W = 3;
  localparam int MM_NC  = 5;
  localparam int BUS_NC = 6;
  localparam int USE_NC = 6;
  // cause codes forced by the stacking context flags
  localparam int MM_STK    = 2;
  localparam int MM_UNSTK  = 3;
  localparam int BUS_STK   = 0;
  localparam int BUS_UNSTK = 1;

  typedef enum logic [1:0] {
    EXC_MEM  = 2'd0,
    EXC_BUS  = 2'd1,
    EXC_USE  = 2'd2,
    EXC_HARD = 2'd3
  } exc_e;
endpackage

// File: rtl/fr_cause_map.sv
`timescale 1ns/1ps
module fr_cause_map #(
  parameter int NC         = 6,
  parameter int CW         = 3,
  parameter int HAS_STK    = 1,
  parameter int STK_CODE   = 0,
  parameter int UNSTK_CODE = 1
) (
  input  logic          req_i,
  input  logic [CW-1:0] code_i,
  input  logic          stk_push_i,
  input  logic          stk_pop_i,
  output logic [NC-1:0] set_o
);
  logic [CW-1:0] eff_code;

  // stacking context overrides the reported cause (R7)
  always_comb begin
    eff_code = code_i;
    if (HAS_STK != 0) begin
      if (stk_push_i)      eff_code = CW'(STK_CODE);
      else if (stk_pop_i)  eff_code = CW'(UNSTK_CODE);
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_dec
    assign set_o[g] = req_i && (eff_code == CW'(g));
  end
endmodule

// File: rtl/fr_arb.sv
`timescale 1ns/1ps
module fr_arb #(
  parameter int NCLS = 3,
  parameter int PB   = 4
) (
  input  logic [NCLS-1:0]         req_i,
  input  logic [NCLS-1:0][PB-1:0] grp_i,
  output logic                    win_vld_o,
  output logic [1:0]              win_cls_o,
  output logic [PB-1:0]           win_grp_o
);
  // strict compare keeps the lower class on a tie (R6)
  always_comb begin
    win_vld_o = 1'b0;
    win_cls_o = 2'd0;
    win_grp_o = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (req_i[i] && (!win_vld_o || (grp_i[i] < win_grp_o))) begin
        win_vld_o = 1'b1;
        win_cls_o = 2'(i);
        win_grp_o = grp_i[i];
      end
    end
  end
endmodule

// File: rtl/fr_decide.sv
`timescale 1ns/1ps
module fr_decide
  import fr_pkg::*;
#(
  parameter int PB = 4
) (
  input  logic          win_vld_i,
  input  logic [1:0]    win_cls_i,
  input  logic [PB-1:0] win_grp_i,
  input  logic [2:0]    hnd_en_i,
  input  logic          exec_act_i,
  input  logic [PB-1:0] exec_grp_i,
  input  logic          fh_act_i,
  input  logic [1:0]    fh_cls_i,
  input  logic          stk_push_i,
  input  logic [1:0]    stk_tgt_i,
  output logic [1:0]    exc_o,
  output logic          esc_o
);
  logic cls_en, prio_blk, self_hit, bus_exempt;

  always_comb begin
    unique case (win_cls_i)
      2'd0:    cls_en = hnd_en_i[0];
      2'd1:    cls_en = hnd_en_i[1];
      2'd2:    cls_en = hnd_en_i[2];
      default: cls_en = 1'b0;
    endcase
  end

  assign prio_blk   = exec_act_i && (win_grp_i >= exec_grp_i);
  assign self_hit   = fh_act_i && (fh_cls_i == win_cls_i);
  assign bus_exempt = (win_cls_i == EXC_BUS) && stk_push_i && (stk_tgt_i == EXC_BUS);

  assign esc_o = win_vld_i && (!cls_en || (!bus_exempt && (prio_blk || self_hit)));
  assign exc_o = esc_o ? EXC_HARD : win_cls_i;
endmodule

// File: rtl/fr_sticky.sv
`timescale 1ns/1ps
module fr_sticky #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_n;
  logic         q_en;

  assign q_en = (|set_i) || (|clr_i);
  assign q_n  = (q_o & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (q_en)  q_o <= q_n;
  end

  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|q_o) && !(|clr_i)) |=> ((q_o & $past(q_o)) == $past(q_o)));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/fault_route_ctrl.sv
`timescale 1ns/1ps
module fault_route_ctrl
  import fr_pkg::*;
#(
  parameter int PW        = 8,
  parameter int PRIO_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fault_req_i,
  input  logic [2:0]        mm_code_i,
  input  logic [2:0]        bus_code_i,
  input  logic [2:0]        use_code_i,
  input  logic              stk_push_i,
  input  logic              stk_pop_i,
  input  logic [1:0]        stk_tgt_i,
  input  logic [2:0]        hnd_en_i,
  input  logic [PW-1:0]     mm_prio_i,
  input  logic [PW-1:0]     bus_prio_i,
  input  logic [PW-1:0]     use_prio_i,
  input  logic              exec_act_i,
  input  logic [PW-1:0]     exec_prio_i,
  input  logic              fh_act_i,
  input  logic [1:0]        fh_cls_i,
  input  logic [MM_NC-1:0]  mm_clr_i,
  input  logic [BUS_NC-1:0] bus_clr_i,
  input  logic [USE_NC-1:0] use_clr_i,
  input  logic              forced_clr_i,
  output logic              take_vld_o,
  output logic [1:0]        take_exc_o,
  output logic              escalated_o,
  output logic [MM_NC-1:0]  mm_sts_o,
  output logic [BUS_NC-1:0] bus_sts_o,
  output logic [USE_NC-1:0] use_sts_o,
  output logic              forced_sts_o
);
  localparam int PB = PRIO_BITS;
  localparam int LB = PW - PB;

  // priority groups: only the upper implemented bits take part (R1)
  logic [NCLS-1:0][PW-1:0] prio_arr;
  logic [NCLS-1:0][PB-1:0] grp_arr;
  logic [PB-1:0]           exec_grp;
  logic                    prio_low_unused;

  assign prio_arr[0] = mm_prio_i;
  assign prio_arr[1] = bus_prio_i;
  assign prio_arr[2] = use_prio_i;

  for (genvar c = 0; c < NCLS; c++) begin : g_grp
    assign grp_arr[c] = prio_arr[c][PW-1 -: PB];
  end
  assign exec_grp        = exec_prio_i[PW-1 -: PB];
  assign prio_low_unused = ^{exec_prio_i[LB-1:0], mm_prio_i[LB-1:0],
                             bus_prio_i[LB-1:0], use_prio_i[LB-1:0]};

  // cause decode per class
  logic [MM_NC-1:0]  mm_set;
  logic [BUS_NC-1:0] bus_set;
  logic [USE_NC-1:0] use_set;

  fr_cause_map #(.NC(MM_NC), .CW(CODE_W), .HAS_STK(1),
                 .STK_CODE(MM_STK), .UNSTK_CODE(MM_UNSTK)) u_map_mm (
    .req_i(fault_req_i[0]), .code_i(mm_code_i), .stk_push_i(stk_push_i),
    .stk_pop_i(stk_pop_i), .set_o(mm_set));

  fr_cause_map #(.NC(BUS_NC), .CW(CODE_W), .HAS_STK(1),
                 .STK_CODE(BUS_STK), .UNSTK_CODE(BUS_UNSTK)) u_map_bus (
    .req_i(fault_req_i[1]), .code_i(bus_code_i), .stk_push_i(stk_push_i),
    .stk_pop_i(stk_pop_i), .set_o(bus_set));

  fr_cause_map #(.NC(USE_NC), .CW(CODE_W), .HAS_STK(0),
                 .STK_CODE(0), .UNSTK_CODE(0)) u_map_use (
    .req_i(fault_req_i[2]), .code_i(use_code_i), .stk_push_i(stk_push_i),
    .stk_pop_i(stk_pop_i), .set_o(use_set));

  // arbitration and decision
  logic          win_vld;
  logic [1:0]    win_cls;
  logic [PB-1:0] win_grp;
  logic [1:0]    dec_exc;
  logic          dec_esc;

  fr_arb #(.NCLS(NCLS), .PB(PB)) u_arb (
    .req_i(fault_req_i), .grp_i(grp_arr),
    .win_vld_o(win_vld), .win_cls_o(win_cls), .win_grp_o(win_grp));

  fr_decide #(.PB(PB)) u_dec (
    .win_vld_i(win_vld), .win_cls_i(win_cls), .win_grp_i(win_grp),
    .hnd_en_i(hnd_en_i), .exec_act_i(exec_act_i), .exec_grp_i(exec_grp),
    .fh_act_i(fh_act_i), .fh_cls_i(fh_cls_i), .stk_push_i(stk_push_i),
    .stk_tgt_i(stk_tgt_i), .exc_o(dec_exc), .esc_o(dec_esc));

  // sticky status
  fr_sticky #(.W(MM_NC))  u_sts_mm  (.clk(clk), .rst_n(rst_n), .set_i(mm_set),
                                     .clr_i(mm_clr_i), .q_o(mm_sts_o));
  fr_sticky #(.W(BUS_NC)) u_sts_bus (.clk(clk), .rst_n(rst_n), .set_i(bus_set),
                                     .clr_i(bus_clr_i), .q_o(bus_sts_o));
  fr_sticky #(.W(USE_NC)) u_sts_use (.clk(clk), .rst_n(rst_n), .set_i(use_set),
                                     .clr_i(use_clr_i), .q_o(use_sts_o));
  fr_sticky #(.W(1))      u_sts_frc (.clk(clk), .rst_n(rst_n), .set_i(dec_esc),
                                     .clr_i(forced_clr_i), .q_o(forced_sts_o));

  // decision register
  logic       take_vld_n, esc_n, exc_en;
  logic [1:0] take_exc_n;

  always_comb begin
    take_vld_n = win_vld;
    esc_n      = dec_esc;
    exc_en     = win_vld;
    take_exc_n = dec_exc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_vld_o  <= 1'b0;
      escalated_o <= 1'b0;
      take_exc_o  <= 2'd0;
    end else begin
      take_vld_o  <= take_vld_n;
      escalated_o <= esc_n;
      if (exc_en) take_exc_o <= take_exc_n;
    end
  end

  // checking aids built from ports and arbiter outputs
  logic win_en, exempt_ctx;
  assign win_en     = (win_cls == EXC_MEM) ? hnd_en_i[0] :
                      (win_cls == EXC_BUS) ? hnd_en_i[1] :
                      (win_cls == EXC_USE) ? hnd_en_i[2] : 1'b0;
  assign exempt_ctx = (win_cls == EXC_BUS) && stk_push_i && (stk_tgt_i == EXC_BUS);

  assert_prio_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && win_en && !exempt_ctx && exec_act_i && (win_grp >= exec_grp))
      |=> (take_exc_o == EXC_HARD));

  assert_self_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && win_en && !exempt_ctx && fh_act_i && (fh_cls_i == win_cls))
      |=> (take_exc_o == EXC_HARD));

  assert_disabled_hard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && !win_en) |=> (take_vld_o && escalated_o && take_exc_o == EXC_HARD));

  assert_stack_exempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && exempt_ctx && hnd_en_i[1]) |=> (take_exc_o == EXC_BUS && !escalated_o));

  assert_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    escalated_o |-> (forced_sts_o && take_vld_o && take_exc_o == EXC_HARD));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fault_req_i) |=> !take_vld_o);
endmodule

// File: tb/sim_fault_route_ctrl.sv
`timescale 1ns/1ps
module sim_fault_route_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [2:0] fault_req, mm_code, bus_code, use_code, hnd_en;
  logic       stk_push, stk_pop, exec_act, fh_act, forced_clr;
  logic [1:0] stk_tgt, fh_cls;
  logic [7:0] mm_prio, bus_prio, use_prio, exec_prio;
  logic [4:0] mm_clr;
  logic [5:0] bus_clr, use_clr;
  logic       take_vld, escalated, forced_sts;
  logic [1:0] take_exc;
  logic [4:0] mm_sts;
  logic [5:0] bus_sts, use_sts;

  fault_route_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fault_req_i(fault_req), .mm_code_i(mm_code),
    .bus_code_i(bus_code), .use_code_i(use_code), .stk_push_i(stk_push),
    .stk_pop_i(stk_pop), .stk_tgt_i(stk_tgt), .hnd_en_i(hnd_en),
    .mm_prio_i(mm_prio), .bus_prio_i(bus_prio), .use_prio_i(use_prio),
    .exec_act_i(exec_act), .exec_prio_i(exec_prio), .fh_act_i(fh_act),
    .fh_cls_i(fh_cls), .mm_clr_i(mm_clr), .bus_clr_i(bus_clr),
    .use_clr_i(use_clr), .forced_clr_i(forced_clr), .take_vld_o(take_vld),
    .take_exc_o(take_exc), .escalated_o(escalated), .mm_sts_o(mm_sts),
    .bus_sts_o(bus_sts), .use_sts_o(use_sts), .forced_sts_o(forced_sts));

  typedef struct packed {
    logic [2:0] req;
    logic [2:0] mmc, busc, usec;
    logic       push, pop;
    logic [1:0] tgt;
    logic [2:0] en;
    logic [7:0] mmp, busp, usep;
    logic       act;
    logic [7:0] cur;
    logic       fha;
    logic [1:0] fhc;
    logic [1:0] xexc;
    logic       xesc;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    // R5 usage divide by zero in thread mode
    '{3'b100,3'd0,3'd0,3'd5,1'b0,1'b0,2'd0,3'b111,8'h00,8'h00,8'h00,1'b0,8'h00,1'b0,2'd0,2'd2,1'b0},
    // R5 memory fault preempts a less urgent exception
    '{3'b001,3'd1,3'd0,3'd0,1'b0,1'b0,2'd0,3'b111,8'h40,8'h00,8'h00,1'b1,8'h80,1'b0,2'd0,2'd0,1'b0},
    // R1 equal priority escalates
    '{3'b001,3'd0,3'd0,3'd0,1'b0,1'b0,2'd0,3'b111,8'h80,8'h00,8'h00,1'b1,8'h80,1'b0,2'd0,2'd3,1'b1},
    // R1 lower bits ignored, groups equal
    '{3'b001,3'd0,3'd0,3'd0,1'b0,1'b0,2'd0,3'b111,8'h40,8'h00,8'h00,1'b1,8'h4F,1'b0,2'd0,2'd3,1'b1},
    // R1 less urgent bus fault escalates
    '{3'b010,3'd0,3'd4,3'd0,1'b0,1'b0,2'd0,3'b111,8'h00,8'hC0,8'h00,1'b1,8'h20,1'b0,2'd0,2'd3,1'b1},
    // R3 usage handler disabled
    '{3'b100,3'd0,3'd0,3'd1,1'b0,1'b0,2'd0,3'b011,8'h00,8'h00,8'h00,1'b0,8'h00,1'b0,2'd0,2'd3,1'b1},
    // R2 bus handler raises bus fault
    '{3'b010,3'd0,3'd2,3'd0,1'b0,1'b0,2'd0,3'b111,8'h00,8'h20,8'h00,1'b1,8'h60,1'b1,2'd1,2'd3,1'b1},
    // R2 other class from a memory handler is fine
    '{3'b010,3'd0,3'd2,3'd0,1'b0,1'b0,2'd0,3'b111,8'h00,8'h20,8'h00,1'b1,8'h60,1'b1,2'd0,2'd1,1'b0},
    // R4 stacking into the bus handler is exempt
    '{3'b010,3'd0,3'd4,3'd0,1'b1,1'b0,2'd1,3'b111,8'h00,8'h60,8'h00,1'b1,8'h60,1'b0,2'd0,2'd1,1'b0},
    // R4 stacking into another handler is not exempt
    '{3'b010,3'd0,3'd4,3'd0,1'b1,1'b0,2'd0,3'b111,8'h00,8'h60,8'h00,1'b1,8'h60,1'b0,2'd0,2'd3,1'b1},
    // R4 exemption does not cover a disabled bus handler
    '{3'b010,3'd0,3'd4,3'd0,1'b1,1'b0,2'd1,3'b101,8'h00,8'h60,8'h00,1'b1,8'h60,1'b0,2'd0,2'd3,1'b1},
    // R7 unstacking flag forces memory code 3
    '{3'b001,3'd0,3'd0,3'd0,1'b0,1'b1,2'd0,3'b111,8'h00,8'h00,8'h00,1'b0,8'h00,1'b0,2'd0,2'd0,1'b0},
    // R7 stacking flag forces memory code 2
    '{3'b001,3'd4,3'd0,3'd0,1'b1,1'b0,2'd0,3'b111,8'h00,8'h00,8'h00,1'b0,8'h00,1'b0,2'd0,2'd0,1'b0},
    // R6 three classes, bus most urgent
    '{3'b111,3'd1,3'd5,3'd3,1'b0,1'b0,2'd0,3'b111,8'h60,8'h30,8'h50,1'b0,8'h00,1'b0,2'd0,2'd1,1'b0},
    // R6 group tie, lower class wins
    '{3'b110,3'd0,3'd3,3'd4,1'b0,1'b0,2'd0,3'b111,8'h00,8'h50,8'h5F,1'b0,8'h00,1'b0,2'd0,2'd1,1'b0},
    // R6 three way tie goes to memory
    '{3'b111,3'd4,3'd2,3'd0,1'b0,1'b0,2'd0,3'b111,8'h20,8'h20,8'h20,1'b0,8'h00,1'b0,2'd0,2'd0,1'b0},
    // R6 winner disabled escalates
    '{3'b101,3'd0,3'd0,3'd2,1'b0,1'b0,2'd0,3'b011,8'h30,8'h00,8'h10,1'b0,8'h00,1'b0,2'd0,2'd3,1'b1},
    // R4 exemption overrides same class and priority rules
    '{3'b010,3'd0,3'd0,3'd0,1'b1,1'b0,2'd1,3'b111,8'h00,8'h70,8'h00,1'b1,8'h60,1'b1,2'd1,2'd1,1'b0},
    // R5 thread mode never escalates on priority
    '{3'b001,3'd0,3'd0,3'd0,1'b0,1'b0,2'd0,3'b111,8'hF0,8'h00,8'h00,1'b0,8'h00,1'b0,2'd0,2'd0,1'b0}
  };

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  function automatic logic [4:0] exp_mm(input vec_t v);
    int c;
    c = v.push ? 2 : (v.pop ? 3 : int'(v.mmc));
    return (v.req[0] && c < 5) ? 5'(1 << c) : 5'd0;
  endfunction

  function automatic logic [5:0] exp_bus(input vec_t v);
    int c;
    c = v.push ? 0 : (v.pop ? 1 : int'(v.busc));
    return (v.req[1] && c < 6) ? 6'(1 << c) : 6'd0;
  endfunction

  function automatic logic [5:0] exp_use(input vec_t v);
    return (v.req[2] && v.usec < 3'd6) ? 6'(1 << v.usec) : 6'd0;
  endfunction

  task automatic idle(input bit clear_all);
    fault_req = 3'b000; stk_push = 1'b0; stk_pop = 1'b0; stk_tgt = 2'd0;
    fh_act = 1'b0; fh_cls = 2'd0; exec_act = 1'b0;
    mm_clr = clear_all ? 5'h1F : 5'h0; bus_clr = clear_all ? 6'h3F : 6'h0;
    use_clr = clear_all ? 6'h3F : 6'h0; forced_clr = clear_all;
  endtask

  task automatic apply(input vec_t v);
    fault_req = v.req; mm_code = v.mmc; bus_code = v.busc; use_code = v.usec;
    stk_push = v.push; stk_pop = v.pop; stk_tgt = v.tgt; hnd_en = v.en;
    mm_prio = v.mmp; bus_prio = v.busp; use_prio = v.usep;
    exec_act = v.act; exec_prio = v.cur; fh_act = v.fha; fh_cls = v.fhc;
    mm_clr = '0; bus_clr = '0; use_clr = '0; forced_clr = 1'b0;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog: got 0 expected 1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    mm_code = '0; bus_code = '0; use_code = '0; hnd_en = 3'b111;
    mm_prio = '0; bus_prio = '0; use_prio = '0; exec_prio = '0;
    idle(1'b0);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 take_vld", 32'(take_vld), 0);
    chk("R10 take_exc", 32'(take_exc), 0);
    chk("R10 escalated", 32'(escalated), 0);
    chk("R10 status", 32'({mm_sts, bus_sts, use_sts, forced_sts}), 0);
    rst_n = 1'b1;
    cycle();

    for (int i = 0; i < NV; i++) begin
      apply(VT[i]);
      cycle();
      chk($sformatf("R11 vector %0d valid", i), 32'(take_vld), 1);
      chk($sformatf("vector %0d exception", i), 32'(take_exc), 32'(VT[i].xexc));
      chk($sformatf("R9 vector %0d escalated", i), 32'(escalated), 32'(VT[i].xesc));
      chk($sformatf("R9 vector %0d forced", i), 32'(forced_sts), 32'(VT[i].xesc));
      chk($sformatf("R7 vector %0d mm status", i), 32'(mm_sts), 32'(exp_mm(VT[i])));
      chk($sformatf("R7 vector %0d bus status", i), 32'(bus_sts), 32'(exp_bus(VT[i])));
      chk($sformatf("R7 vector %0d use status", i), 32'(use_sts), 32'(exp_use(VT[i])));
      idle(1'b1);
      cycle();
      chk($sformatf("R11 vector %0d idle", i), 32'(take_vld), 0);
      chk($sformatf("R8 vector %0d cleared", i),
          32'({mm_sts, bus_sts, use_sts, forced_sts}), 0);
    end

    // R7 stickiness across idle cycles and accumulation
    idle(1'b0); hnd_en = 3'b111;
    fault_req = 3'b100; use_code = 3'd1;
    cycle();
    idle(1'b0);
    repeat (3) cycle();
    chk("R7 use status held", 32'(use_sts), 32'h02);
    fault_req = 3'b100; use_code = 3'd4;
    cycle();
    idle(1'b0);
    cycle();
    chk("R7 use status accumulates", 32'(use_sts), 32'h12);
    // R8 partial clear
    use_clr = 6'h02;
    cycle();
    use_clr = 6'h00;
    cycle();
    chk("R8 partial clear", 32'(use_sts), 32'h10);
    // R8 set wins over clear in the same cycle
    fault_req = 3'b100; use_code = 3'd4; use_clr = 6'h10;
    cycle();
    idle(1'b0);
    cycle();
    chk("R8 set beats clear", 32'(use_sts), 32'h10);
    // R7 out-of-range code sets nothing but is still serviced
    idle(1'b1);
    cycle();
    idle(1'b0);
    fault_req = 3'b100; use_code = 3'd7;
    cycle();
    chk("R5 out-of-range code serviced", 32'(take_exc), 2);
    chk("R7 out-of-range code no status", 32'(use_sts), 0);
    // R9 forced bit holds until cleared
    idle(1'b0);
    fault_req = 3'b001; hnd_en = 3'b110;
    cycle();
    idle(1'b0); hnd_en = 3'b111;
    repeat (2) cycle();
    chk("R9 forced held", 32'(forced_sts), 1);
    chk("R9 escalated drops", 32'(escalated), 0);
    forced_clr = 1'b1;
    cycle();
    forced_clr = 1'b0;
    cycle();
    chk("R9 forced cleared", 32'(forced_sts), 0);
    chk("R7 mm status kept", 32'(mm_sts), 32'h01);

    finish_run();
  end
endmodule